// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Registers

This block holds the software-visible registers of one memory-copy DMA channel: the descriptor ring base address, the next-descriptor pointer, the ring length, the prefetch limit, the maximum transfer size, a control register, an interrupt enable register and an interrupt status register. Software reaches them over a simple word-indexed register bus. Writes take effect on the clock edge, and reads return the addressed word combinationally.

The descriptor engine sits outside this block. The block starts that engine with a one-cycle pulse. It carries the graceful-pause and abort requests to the engine and holds each request until the engine reports completion. When completion arrives, it records a sticky done flag. Engine events set sticky flags that software clears by writing one to them. A level interrupt is the OR of the enabled flags. Ring configuration is locked while the engine reports that it is busy.

Top module: `dmach_regs`

## Requirements
- R1: After reset every register index 0 to 15 reads zero, and `irq_o`, `eng_start_o`, `eng_pause_req_o` and `eng_abort_req_o` are low.
- R2: The register map by word index is: 0 ring base low (32 bits), 1 ring base high (ADDR_HI_W bits), 2 next-descriptor address (32 bits), 3 ring count (RCNT_W bits), 4 prefetch limit (PREF_W bits), 5 control, 6 transfer size code, 7 interrupt enable, 8 interrupt status. Indices 9 to 15 read zero, and bits above a field's width read zero.
- R3: While `eng_busy_i` is high, writes to ring base low, ring base high and ring count are ignored. Writes to the next-descriptor address still take effect.
- R4: Control bits 0 (pause request), 1 (abort request), 2 (write-back enable), 4 (ring stop mode) and 6:5 (descriptor mode) are read/write. Writing 1 to bit 3 makes `eng_start_o` high for exactly the cycle after the write. Bit 3 reads zero.
- R5: Control bit 30 reads the current level of `eng_busy_i`.
- R6: Control bit 0 drives `eng_pause_req_o`. When `eng_pause_done_i` arrives, bit 0 clears and bit 9 becomes set. Abort works the same way: bit 1 drives `eng_abort_req_o`, and `eng_abort_done_i` clears bit 1 and sets bit 10.
- R7: Control sticky bits are set by events: bit 8 by `eng_inv_desc_i`, bit 9 by `eng_pause_done_i`, bit 10 by `eng_abort_done_i`, bit 12 by `eng_imm_pause_done_i`. Writing 1 to one of these bits clears it. An event in the same cycle as the clear wins.
- R8: The transfer size code (3 bits) accepts 0=64B, 1=128B, 2=256B, 3=512B, 4=1KB, 5=2KB and 7=4B. A write of code 6 leaves the stored code unchanged. The code appears on `xfer_size_o`.
- R9: Interrupt status bits are set by events: bit 0 by `eng_err_i`, bit 1 by `eng_inv_desc_i`, bit 2 by `eng_desc_done_i` only when `eng_desc_irq_i` is high in the same cycle, and bit 3 by `eng_abort_done_i`. Writing 1 clears a bit. An event in the same cycle as the clear wins.
- R10: Interrupt enable bits 0, 1, 3, 4 and 5 are read/write, and its other bits read zero. `irq_o` = (sts0&en0) | (sts1&en1) | sts2 | (sts3&en3) | (ctrl9&en4) | (ctrl12&en5). The descriptor-done status has no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| ring_base_o | output | ADDR_HI_W+32 | Descriptor ring base address |
| next_desc_o | output | 32 | Next-descriptor address |
| ring_count_o | output | RCNT_W | Ring length in descriptors |
| pref_limit_o | output | PREF_W | Prefetch limit |
| xfer_size_o | output | 3 | Maximum transfer size code |
| desc_mode_o | output | 2 | Descriptor mode |
| wb_en_o | output | 1 | Write-back enable |
| ring_stop_o | output | 1 | Ring stop mode |
| eng_start_o | output | 1 | One-cycle start pulse |
| eng_pause_req_o | output | 1 | Graceful pause request |
| eng_abort_req_o | output | 1 | Abort request |
| eng_busy_i | input | 1 | Engine has a transfer in progress |
| eng_desc_done_i | input | 1 | A descriptor completed |
| eng_desc_irq_i | input | 1 | Completed descriptor asks for an interrupt |
| eng_err_i | input | 1 | Transfer error |
| eng_inv_desc_i | input | 1 | Invalid descriptor seen |
| eng_pause_done_i | input | 1 | Graceful pause completed |
| eng_abort_done_i | input | 1 | Abort completed |
| eng_imm_pause_done_i | input | 1 | Immediate pause completed |
| irq_o | output | 1 | Level interrupt |

## Verification
A lost or wrongly set sticky flag shows on `irq_o` in the same cycle that its register updates, which is the cycle after the event. For that reason the bench sweeps every combination of six engine events against every enable pattern and compares `irq_o` with the sum-of-products formula. A wrong request register shows at once on `eng_pause_req_o` or `eng_abort_req_o`. A lapse in the busy lock or the size-code filter shows on the next read of that register and on its configuration output.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam logic [3:0] A_RING_LO = 4'd0;
  localparam logic [3:0] A_RING_HI = 4'd1;
  localparam logic [3:0] A_NEXT    = 4'd2;
  localparam logic [3:0] A_COUNT   = 4'd3;
  localparam logic [3:0] A_PREF    = 4'd4;
  localparam logic [3:0] A_CTRL    = 4'd5;
  localparam logic [3:0] A_SIZE    = 4'd6;
  localparam logic [3:0] A_INT_EN  = 4'd7;
  localparam logic [3:0] A_INT_STS = 4'd8;

  localparam int C_PAUSE = 0;
  localparam int C_ABORT = 1;
  localparam int C_WB    = 2;
  localparam int C_START = 3;
  localparam int C_STOP  = 4;
  localparam int C_MODE  = 5;
  localparam int C_BUSY  = 30;

  // sticky control flags, index into the flag vector and bit position
  localparam int N_STICKY = 4;
  localparam int K_INV = 0, K_PDONE = 1, K_ADONE = 2, K_IDONE = 3;
  localparam int STICKY_POS [N_STICKY] = '{8, 9, 10, 12};

  localparam int S_ERR = 0, S_INV = 1, S_DESC = 2, S_ABORT = 3;
  localparam int N_STS = 4;
  localparam logic [5:0] EN_MASK = 6'b111011;

  localparam logic [2:0] SIZE_RSVD = 3'd6;
endpackage

// File: rtl/dmach_cfg.sv
module dmach_cfg
  import dmach_pkg::*;
#(
  parameter int ADDR_HI_W = 16,
  parameter int RCNT_W    = 16,
  parameter int PREF_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [3:0]           widx_i,
  input  logic [31:0]          wdata_i,
  input  logic                 busy_i,
  output logic [31:0]          ring_lo_o,
  output logic [ADDR_HI_W-1:0] ring_hi_o,
  output logic [31:0]          next_o,
  output logic [RCNT_W-1:0]    count_o,
  output logic [PREF_W-1:0]    pref_o,
  output logic [2:0]           size_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[31:3];

  logic lock;
  assign lock = busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_lo_o <= '0;
      ring_hi_o <= '0;
      next_o    <= '0;
      count_o   <= '0;
      pref_o    <= '0;
      size_o    <= '0;
    end else if (wr_i) begin
      case (widx_i)
        A_RING_LO: if (!lock) ring_lo_o <= wdata_i;
        A_RING_HI: if (!lock) ring_hi_o <= wdata_i[ADDR_HI_W-1:0];
        A_COUNT:   if (!lock) count_o   <= wdata_i[RCNT_W-1:0];
        A_NEXT:    next_o <= wdata_i;
        A_PREF:    pref_o <= wdata_i[PREF_W-1:0];
        A_SIZE:    if (wdata_i[2:0] != SIZE_RSVD) size_o <= wdata_i[2:0];
        default: ;
      endcase
    end
  end

  // R3
  ring_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i && (widx_i == A_RING_LO || widx_i == A_COUNT)) |=>
      ($stable(ring_lo_o) && $stable(count_o)));
  // R8
  size_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && widx_i == A_SIZE && wdata_i[2:0] == SIZE_RSVD) |=> $stable(size_o));
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        inv_i,
  input  logic        pdone_i,
  input  logic        adone_i,
  input  logic        idone_i,
  output logic [31:0] rd_o,
  output logic        pause_req_o,
  output logic        abort_req_o,
  output logic        wb_en_o,
  output logic        ring_stop_o,
  output logic [1:0]  mode_o,
  output logic        start_o,
  output logic        pdone_flag_o,
  output logic        idone_flag_o
);
  logic [N_STICKY-1:0] ev, flag_q;
  assign ev[K_INV]   = inv_i;
  assign ev[K_PDONE] = pdone_i;
  assign ev[K_ADONE] = adone_i;
  assign ev[K_IDONE] = idone_i;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:13], wdata_i[11], wdata_i[7]};

  // sticky flags: write-one-to-clear, event wins
  for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else flag_q[k] <= (flag_q[k] & ~(wr_i & wdata_i[STICKY_POS[k]])) | ev[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_req_o <= 1'b0;
      abort_req_o <= 1'b0;
      wb_en_o     <= 1'b0;
      ring_stop_o <= 1'b0;
      mode_o      <= '0;
      start_o     <= 1'b0;
    end else begin
      start_o <= wr_i & wdata_i[C_START];
      if (wr_i) begin
        wb_en_o     <= wdata_i[C_WB];
        ring_stop_o <= wdata_i[C_STOP];
        mode_o      <= wdata_i[C_MODE+1:C_MODE];
      end
      if (pdone_i)   pause_req_o <= 1'b0;
      else if (wr_i) pause_req_o <= wdata_i[C_PAUSE];
      if (adone_i)   abort_req_o <= 1'b0;
      else if (wr_i) abort_req_o <= wdata_i[C_ABORT];
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[C_PAUSE] = pause_req_o;
    rd_o[C_ABORT] = abort_req_o;
    rd_o[C_WB]    = wb_en_o;
    rd_o[C_STOP]  = ring_stop_o;
    rd_o[C_MODE+1:C_MODE] = mode_o;
    for (int k = 0; k < N_STICKY; k++) rd_o[STICKY_POS[k]] = flag_q[k];
    rd_o[C_BUSY]  = busy_i;
  end

  assign pdone_flag_o = flag_q[K_PDONE];
  assign idone_flag_o = flag_q[K_IDONE];

  // R6
  pause_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdone_i |=> (!pause_req_o && pdone_flag_o));
  // R6
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adone_i |=> (!abort_req_o && flag_q[K_ADONE]));
  // R7
  pdone_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdone_flag_o) |-> $past(pdone_i));
  // R7
  inv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> flag_q[K_INV]);
endmodule

// File: rtl/dmach_irq.sv
module dmach_irq
  import dmach_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sts_i,
  input  logic [31:0]      wdata_i,
  input  logic             err_i,
  input  logic             inv_i,
  input  logic             desc_done_i,
  input  logic             desc_irq_i,
  input  logic             adone_i,
  input  logic             pdone_flag_i,
  input  logic             idone_flag_i,
  output logic [5:0]       en_o,
  output logic [N_STS-1:0] sts_o,
  output logic             irq_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[31:6];

  logic [N_STS-1:0] set, clr;
  assign set[S_ERR]   = err_i;
  assign set[S_INV]   = inv_i;
  assign set[S_DESC]  = desc_done_i & desc_irq_i;
  assign set[S_ABORT] = adone_i;
  assign clr = wr_sts_i ? wdata_i[N_STS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      sts_o <= '0;
    end else begin
      if (wr_en_i) en_o <= wdata_i[5:0] & EN_MASK;
      sts_o <= (sts_o & ~clr) | set;
    end
  end

  assign irq_o = (sts_o[S_ERR] & en_o[0]) | (sts_o[S_INV] & en_o[1]) |
                 sts_o[S_DESC] | (sts_o[S_ABORT] & en_o[3]) |
                 (pdone_flag_i & en_o[4]) | (idone_flag_i & en_o[5]);

  // R9
  desc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_done_i && !desc_irq_i && !sts_o[S_DESC]) |=> !sts_o[S_DESC]);
  // R9
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> sts_o[S_ERR]);
  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0 && !sts_o[S_DESC]) |-> !irq_o);
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_HI_W = 16,
  parameter int RCNT_W    = 16,
  parameter int PREF_W    = 8,
  localparam int BASE_W   = ADDR_HI_W + 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [BASE_W-1:0] ring_base_o,
  output logic [31:0]       next_desc_o,
  output logic [RCNT_W-1:0] ring_count_o,
  output logic [PREF_W-1:0] pref_limit_o,
  output logic [2:0]        xfer_size_o,
  output logic [1:0]        desc_mode_o,
  output logic              wb_en_o,
  output logic              ring_stop_o,
  output logic              eng_start_o,
  output logic              eng_pause_req_o,
  output logic              eng_abort_req_o,
  input  logic              eng_busy_i,
  input  logic              eng_desc_done_i,
  input  logic              eng_desc_irq_i,
  input  logic              eng_err_i,
  input  logic              eng_inv_desc_i,
  input  logic              eng_pause_done_i,
  input  logic              eng_abort_done_i,
  input  logic              eng_imm_pause_done_i,
  output logic              irq_o
);
  logic wr;
  assign wr = req_i & we_i;

  logic [31:0]          ring_lo;
  logic [ADDR_HI_W-1:0] ring_hi;
  logic [31:0]          ctrl_rd;
  logic [5:0]           int_en;
  logic [N_STS-1:0]     int_sts;
  logic                 pdone_flag, idone_flag;

  dmach_cfg #(.ADDR_HI_W(ADDR_HI_W), .RCNT_W(RCNT_W), .PREF_W(PREF_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i(wr), .widx_i(addr_i), .wdata_i, .busy_i(eng_busy_i),
    .ring_lo_o(ring_lo), .ring_hi_o(ring_hi), .next_o(next_desc_o),
    .count_o(ring_count_o), .pref_o(pref_limit_o), .size_o(xfer_size_o)
  );

  dmach_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr && addr_i == A_CTRL), .wdata_i, .busy_i(eng_busy_i),
    .inv_i(eng_inv_desc_i), .pdone_i(eng_pause_done_i),
    .adone_i(eng_abort_done_i), .idone_i(eng_imm_pause_done_i),
    .rd_o(ctrl_rd), .pause_req_o(eng_pause_req_o), .abort_req_o(eng_abort_req_o),
    .wb_en_o, .ring_stop_o, .mode_o(desc_mode_o), .start_o(eng_start_o),
    .pdone_flag_o(pdone_flag), .idone_flag_o(idone_flag)
  );

  dmach_irq u_irq (
    .clk_i, .rst_ni,
    .wr_en_i(wr && addr_i == A_INT_EN), .wr_sts_i(wr && addr_i == A_INT_STS),
    .wdata_i, .err_i(eng_err_i), .inv_i(eng_inv_desc_i),
    .desc_done_i(eng_desc_done_i), .desc_irq_i(eng_desc_irq_i),
    .adone_i(eng_abort_done_i), .pdone_flag_i(pdone_flag),
    .idone_flag_i(idone_flag), .en_o(int_en), .sts_o(int_sts), .irq_o
  );

  assign ring_base_o = {ring_hi, ring_lo};

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RING_LO: rdata_o = ring_lo;
      A_RING_HI: rdata_o[ADDR_HI_W-1:0] = ring_hi;
      A_NEXT:    rdata_o = next_desc_o;
      A_COUNT:   rdata_o[RCNT_W-1:0] = ring_count_o;
      A_PREF:    rdata_o[PREF_W-1:0] = pref_limit_o;
      A_CTRL:    rdata_o = ctrl_rd;
      A_SIZE:    rdata_o[2:0] = xfer_size_o;
      A_INT_EN:  rdata_o[5:0] = int_en;
      A_INT_STS: rdata_o[N_STS-1:0] = int_sts;
      default: ;
    endcase
  end

  // R4
  start_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_start_o) |-> $past(wr && addr_i == A_CTRL));
endmodule

// File: tb/dmach_regs_tb.sv
`timescale 1ns/1ps
module dmach_regs_tb_top;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [47:0] ring_base;
  logic [31:0] next_desc;
  logic [15:0] ring_count;
  logic [7:0] pref;
  logic [2:0] xsize;
  logic [1:0] dmode;
  logic wb_en, rstop, start, preq, areq, irq;
  logic busy = 0, ddone = 0, dirq = 0, err = 0, inv = 0, pdone = 0, adone = 0, idone = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  dmach_regs dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ring_base_o(ring_base), .next_desc_o(next_desc),
    .ring_count_o(ring_count), .pref_limit_o(pref), .xfer_size_o(xsize),
    .desc_mode_o(dmode), .wb_en_o(wb_en), .ring_stop_o(rstop),
    .eng_start_o(start), .eng_pause_req_o(preq), .eng_abort_req_o(areq),
    .eng_busy_i(busy), .eng_desc_done_i(ddone), .eng_desc_irq_i(dirq),
    .eng_err_i(err), .eng_inv_desc_i(inv), .eng_pause_done_i(pdone),
    .eng_abort_done_i(adone), .eng_imm_pause_done_i(idone), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // bit order: err, inv, desc(with irq flag), abort_done, pause_done, imm_pause_done
  task automatic ev(input logic [5:0] e);
    @(negedge clk);
    err = e[0]; inv = e[1]; ddone = e[2]; dirq = e[2]; adone = e[3]; pdone = e[4]; idone = e[5];
    @(negedge clk);
    {err, inv, ddone, dirq, adone, pdone, idone} = '0;
  endtask

  function automatic logic [31:0] fmask(input int idx);
    case (idx)
      0, 2: return 32'hFFFF_FFFF;
      1, 3: return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [2:0] sz_exp;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin rd(4'(i), r); chk($sformatf("R1 reg %0d", i), r, 0); end
    chk("R1 outputs", {irq, start, preq, areq}, 0);

    // R2: walking ones over the plain registers, width masks, unmapped reads
    for (int i = 0; i < 5; i++)
      for (int b = 0; b < 32; b++) begin
        wr(4'(i), 32'd1 << b);
        rd(4'(i), r);
        chk($sformatf("R2 reg %0d bit %0d", i, b), r, (32'd1 << b) & fmask(i));
      end
    for (int i = 0; i < 5; i++) wr(4'(i), 32'hFFFF_FFFF);
    chk("R2 base port", ring_base, 48'hFFFF_FFFF_FFFF);
    chk("R2 cfg ports", {next_desc, ring_count, pref}, {32'hFFFF_FFFF, 16'hFFFF, 8'hFF});
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, r); chk("R2 unmapped", r, 0);

    // R3: busy lock
    wr(4'd0, 32'h1111_0000); wr(4'd1, 32'h22); wr(4'd3, 32'h33); wr(4'd2, 32'h44);
    busy = 1;
    wr(4'd0, 32'hAAAA_5555); wr(4'd1, 32'h99); wr(4'd3, 32'h77); wr(4'd2, 32'h88);
    rd(4'd0, r); chk("R3 base lo locked", r, 32'h1111_0000);
    rd(4'd1, r); chk("R3 base hi locked", r, 32'h22);
    rd(4'd3, r); chk("R3 count locked", r, 32'h33);
    rd(4'd2, r); chk("R3 next still written", r, 32'h88);
    // R5
    rd(4'd5, r); chk("R5 busy bit", r[30], 1'b1);
    busy = 0;
    rd(4'd5, r); chk("R5 idle bit", r[30], 1'b0);
    wr(4'd0, 32'hAAAA_5555); rd(4'd0, r); chk("R3 unlocked write", r, 32'hAAAA_5555);

    // R4: control fields and start pulse
    wr(4'd5, 32'h74); rd(4'd5, r); chk("R4 ctrl rw fields", r, 32'h74);
    chk("R4 field ports", {wb_en, rstop, dmode}, {1'b1, 1'b1, 2'd3});
    wr(4'd5, 32'h4C);
    chk("R4 start pulse high", start, 1'b1);
    rd(4'd5, r); chk("R4 start reads zero", r, 32'h44);
    @(negedge clk); chk("R4 start pulse one cycle", start, 1'b0);

    // R6: pause and abort handshakes
    wr(4'd5, 32'h1); chk("R6 pause req out", preq, 1'b1);
    ev(6'b010000);
    rd(4'd5, r); chk("R6 pause done flags", r & 32'h203, 32'h200);
    chk("R6 pause req dropped", preq, 1'b0);
    wr(4'd5, 32'h2); chk("R6 abort req out", areq, 1'b1);
    ev(6'b001000);
    rd(4'd5, r); chk("R6 abort done flags", r & 32'h603, 32'h600);
    rd(4'd8, r); chk("R6 abort status", r, 32'h8);
    chk("R6 abort req dropped", areq, 1'b0);

    // R7: W1C on control stickies, event beats clear
    ev(6'b100010);
    rd(4'd5, r); chk("R7 all stickies set", r & 32'h1700, 32'h1700);
    wr(4'd5, 32'h0200); rd(4'd5, r); chk("R7 clear pause done only", r & 32'h1700, 32'h1500);
    @(negedge clk);
    req = 1; we = 1; addr = 4'd5; wdata = 32'h1500; inv = 1;
    @(negedge clk);
    req = 0; we = 0; inv = 0;
    rd(4'd5, r); chk("R7 set wins over clear", r & 32'h1700, 32'h0100);
    wr(4'd5, 32'h1700); wr(4'd8, 32'hF);
    rd(4'd5, r); chk("R7 all cleared", r & 32'h1700, 0);

    // R8: every size code
    for (int c = 0; c < 8; c++) begin
      wr(4'd6, 32'd5);
      wr(4'd6, 32'(c));
      sz_exp = (c == 6) ? 3'd5 : 3'(c);
      rd(4'd6, r);
      chk($sformatf("R8 size code %0d", c), r, {29'd0, sz_exp});
      chk($sformatf("R8 size port %0d", c), xsize, sz_exp);
    end

    // R9: status setting, desc gate, W1C and set-wins
    @(negedge clk); ddone = 1; dirq = 0; @(negedge clk); ddone = 0;
    rd(4'd8, r); chk("R9 desc without irq flag", r, 0);
    ev(6'b001111); rd(4'd8, r); chk("R9 all status set", r, 32'hF);
    wr(4'd8, 32'h5); rd(4'd8, r); chk("R9 w1c", r, 32'hA);
    @(negedge clk);
    req = 1; we = 1; addr = 4'd8; wdata = 32'hF; err = 1;
    @(negedge clk);
    req = 0; we = 0; err = 0;
    rd(4'd8, r); chk("R9 set wins", r, 32'h1);
    wr(4'd8, 32'hF); wr(4'd5, 32'h1700);

    // R10: enable mask and full sweep of events x enables
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, r); chk("R10 enable mask", r, 32'h3B);
    for (int e = 0; e < 64; e++)
      for (int n = 0; n < 64; n++) begin
        wr(4'd7, 32'(n));
        ev(6'(e));
        chk($sformatf("R10 irq ev=%0h en=%0h", e, n), irq,
            (e[0] & n[0]) | (e[1] & n[1]) | e[2] | (e[3] & n[3]) | (e[4] & n[4]) | (e[5] & n[5]));
        wr(4'd8, 32'hF); wr(4'd5, 32'h1700);
      end
    chk("R10 irq after clear", irq, 1'b0);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule